// File: doc/BRIEF.md
# DRAM Mode Register and Write-Latency Sequencer

This block sits on the device side of a synchronous DRAM model. It watches a decoded command stream. When it sees a mode-set command it captures the address bus into a mode register. That register holds four things: a write-recovery value, a write-latency value, a test-mode flag and a self-clearing DLL-reset flag.

When a write command is registered, the block schedules a data capture. The capture lands exactly the programmed number of clock edges later. It raises a one-cycle strobe with the sampled data word for each beat.

The block also drives an input-receiver enable. For short latencies the receivers are kept on permanently. For long latencies they are switched on only from the cycle after a write is registered until its last beat has been taken. This saves power while the bus is idle.

A DLL reset requested through the mode register produces a start pulse for the external DLL logic. The stored flag clears itself after a fixed number of cycles. Any further accepted mode-set that arrives during that window restarts the count.

Top module: `mrs_wl_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves write latency 1, write recovery 0, test mode off, DLL-reset flag off, no capture strobe and the receiver enable high.
- R2: A mode-set command (cmdIn = 2'b01) whose latency field addrIn[6:4] lies in 1..7 loads write recovery from addrIn[2:0], write latency from addrIn[6:4] and test mode from addrIn[7]. Bits 3 and 9..12 have no effect.
- R3: A mode-set whose latency field addrIn[6:4] is 0 is rejected. Write recovery, write latency and test mode keep their old values, and no DLL reset starts even if addrIn[8] is 1.
- R4: A write command (cmdIn = 2'b10) registered at edge n while the latency is m samples dataIn at edges n+m through n+m+BURST_LEN-1. In the cycle after each of those edges, capStrobe is 1 and capData holds the word sampled there. Each write uses the latency in force when it was registered.
- R5: Writes registered on consecutive edges each produce their own capture at their own edge, with no capture lost.
- R6: While the write latency is at most ALWAYS_ON_MAX (default 5), rxEnable stays 1.
- R7: While the write latency exceeds ALWAYS_ON_MAX, rxEnable is 0 when no capture is pending. It rises in the cycle after a write is registered and falls in the cycle after the last pending capture edge. Closely spaced writes keep it high throughout.
- R8: An accepted mode-set with addrIn[8] = 1 sets dllResetBit and gives a one-cycle dllResetPulse in the following cycle. dllResetBit returns to 0 by itself DLL_CYCLES (default 16) edges later.
- R9: An accepted mode-set arriving while dllResetBit is 1 restarts the DLL_CYCLES count and pulses dllResetPulse again, whatever its addrIn[8] value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdIn | input | 2 | Command: 00 no-op, 01 mode-set, 10 write, 11 no-op |
| addrIn | input | ADDR_W (13) | Address bus, decoded on mode-set |
| dataIn | input | DATA_W (16) | Write data bus |
| writeLatency | output | 3 | Programmed write latency |
| wrRecovery | output | 3 | Programmed write-recovery value |
| testMode | output | 1 | Test-mode flag |
| dllResetBit | output | 1 | Stored DLL-reset flag, self clearing |
| dllResetPulse | output | 1 | One-cycle DLL reset start pulse |
| rxEnable | output | 1 | Input-receiver enable |
| capStrobe | output | 1 | Data capture strobe |
| capData | output | DATA_W (16) | Captured write data |

## Verification
The hardest state to reach from the ports is several writes in flight at once, issued under different latencies. That state needs a mode-set changing the latency between two writes, while a long-latency write is still pending. The stimulus issues a write at latency 7, reprograms to latency 2 on the next cycle and writes again, so the second capture overtakes the first. A restarted DLL reset is reached the same way, by a second mode-set placed inside the count window. A changing data pattern tied to the edge number shows that each capture took the word from its own edge.

// File: rtl/mrs_wl_pkg.sv
package mrs_wl_pkg;

  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_MRS   = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  // Field layout of the mode word on the address bus
  localparam int FIELD_W = 3;
  localparam int WR_LSB  = 0;
  localparam int WL_LSB  = 4;
  localparam int TM_BIT  = 7;
  localparam int DLL_BIT = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadMode;    // accepted mode-set this cycle
    logic dllRequest;  // DLL-reset bit of the mode word
    logic capture;     // sample dataIn at this edge
  } strobes_t;

endpackage

// File: rtl/mrs_wl_ctrl.sv
module mrs_wl_ctrl
  import mrs_wl_pkg::*;
#(
  parameter int WL_MAX        = 7,
  parameter int BURST_LEN     = 1,
  parameter int ALWAYS_ON_MAX = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmdRaw,
  input  logic [FIELD_W-1:0] wlField,
  input  logic               dllField,
  input  logic [FIELD_W-1:0] curWl,
  output strobes_t           strobes,
  output logic               rxEnable
);

  localparam int PEND_W = WL_MAX + BURST_LEN - 1;
  localparam logic [PEND_W-1:0] BURST_MASK = PEND_W'({BURST_LEN{1'b1}});

  cmd_e cmd;
  logic isWrite;
  logic isMrs;
  logic wlLegal;
  logic [PEND_W-1:0] pend;
  logic [PEND_W-1:0] newSlots;
  logic [PEND_W-1:0] pendNext;

  assign cmd     = cmd_e'(cmdRaw);
  assign isWrite = (cmd == CMD_WRITE);
  assign isMrs   = (cmd == CMD_MRS);
  assign wlLegal = (wlField != '0) && (int'(wlField) <= WL_MAX);

  // Bit k of pend: a capture is due k+1 edges from now
  assign newSlots = isWrite ? (BURST_MASK << (curWl - FIELD_W'(1))) : '0;
  assign pendNext = (pend >> 1) | newSlots;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pendNext;
  end

  assign strobes.loadMode   = isMrs && wlLegal;
  assign strobes.dllRequest = dllField;
  assign strobes.capture    = pend[0];

  generate
    if (ALWAYS_ON_MAX >= WL_MAX) begin : g_rx_fixed
      assign rxEnable = 1'b1;
    end else begin : g_rx_gated
      assign rxEnable = (int'(curWl) <= ALWAYS_ON_MAX) || (|pend);
    end
  endgenerate

endmodule

// File: rtl/mrs_wl_datapath.sv
module mrs_wl_datapath
  import mrs_wl_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DLL_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  strobes_t           strobes,
  input  logic [FIELD_W-1:0] wrField,
  input  logic [FIELD_W-1:0] wlField,
  input  logic               tmField,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [FIELD_W-1:0] wrRecovery,
  output logic [FIELD_W-1:0] writeLatency,
  output logic               testMode,
  output logic               dllResetBit,
  output logic               dllResetPulse,
  output logic               capStrobe,
  output logic [DATA_W-1:0]  capData
);

  localparam int CNT_W = $clog2(DLL_CYCLES + 1);

  logic [CNT_W-1:0] dllCnt;
  logic             restart;

  assign restart = strobes.loadMode && (strobes.dllRequest || dllResetBit);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrRecovery   <= '0;
      writeLatency <= FIELD_W'(1);
      testMode     <= 1'b0;
    end else if (strobes.loadMode) begin
      wrRecovery   <= wrField;
      writeLatency <= wlField;
      testMode     <= tmField;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dllResetBit   <= 1'b0;
      dllCnt        <= '0;
      dllResetPulse <= 1'b0;
    end else begin
      dllResetPulse <= restart;
      if (restart) begin
        dllResetBit <= 1'b1;
        dllCnt      <= CNT_W'(DLL_CYCLES);
      end else if (dllResetBit) begin
        if (dllCnt == CNT_W'(1)) begin
          dllResetBit <= 1'b0;
          dllCnt      <= '0;
        end else begin
          dllCnt <= dllCnt - CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capStrobe <= 1'b0;
      capData   <= '0;
    end else begin
      capStrobe <= strobes.capture;
      if (strobes.capture) capData <= dataIn;
    end
  end

endmodule

// File: rtl/mrs_wl_sequencer.sv
module mrs_wl_sequencer
  import mrs_wl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 16,
  parameter int WL_MAX        = 7,
  parameter int BURST_LEN     = 1,
  parameter int ALWAYS_ON_MAX = 5,
  parameter int DLL_CYCLES    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cmdIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  dataIn,
  output logic [FIELD_W-1:0] writeLatency,
  output logic [FIELD_W-1:0] wrRecovery,
  output logic               testMode,
  output logic               dllResetBit,
  output logic               dllResetPulse,
  output logic               rxEnable,
  output logic               capStrobe,
  output logic [DATA_W-1:0]  capData
);

  strobes_t strobes;

  mrs_wl_ctrl #(
    .WL_MAX(WL_MAX), .BURST_LEN(BURST_LEN), .ALWAYS_ON_MAX(ALWAYS_ON_MAX)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cmdRaw  (cmdIn),
    .wlField (addrIn[WL_LSB +: FIELD_W]),
    .dllField(addrIn[DLL_BIT]),
    .curWl   (writeLatency),
    .strobes (strobes),
    .rxEnable(rxEnable)
  );

  mrs_wl_datapath #(
    .DATA_W(DATA_W), .DLL_CYCLES(DLL_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobes      (strobes),
    .wrField      (addrIn[WR_LSB +: FIELD_W]),
    .wlField      (addrIn[WL_LSB +: FIELD_W]),
    .tmField      (addrIn[TM_BIT]),
    .dataIn       (dataIn),
    .wrRecovery   (wrRecovery),
    .writeLatency (writeLatency),
    .testMode     (testMode),
    .dllResetBit  (dllResetBit),
    .dllResetPulse(dllResetPulse),
    .capStrobe    (capStrobe),
    .capData      (capData)
  );

endmodule

// File: rtl/mrs_wl_checker.sv
module mrs_wl_checker
  import mrs_wl_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int ALWAYS_ON_MAX = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         cmdIn,
  input logic [ADDR_W-1:0]  addrIn,
  input logic [FIELD_W-1:0] writeLatency,
  input logic               testMode,
  input logic               dllResetBit,
  input logic               dllResetPulse,
  input logic               rxEnable,
  input logic               capStrobe
);

  logic mrsSeen, writeSeen, legalWl;
  assign mrsSeen   = (cmdIn == CMD_MRS);
  assign writeSeen = (cmdIn == CMD_WRITE);
  assign legalWl   = (addrIn[WL_LSB +: FIELD_W] != '0);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (writeLatency == FIELD_W'(1)) && !testMode && !dllResetBit && !capStrobe);

  p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
    (mrsSeen && legalWl) |=> (writeLatency == $past(addrIn[WL_LSB +: FIELD_W]))
                              && (testMode == $past(addrIn[TM_BIT])));

  p_reject_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (mrsSeen && !legalWl) |=> $stable(writeLatency) && $stable(testMode) && !dllResetPulse);

  p_wl1_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (writeSeen && writeLatency == FIELD_W'(1)) |=> ##1 capStrobe);

  p_always_on_r6: assert property (@(posedge clk) disable iff (rst)
    (int'(writeLatency) <= ALWAYS_ON_MAX) |-> rxEnable);

  p_rx_rise_r7: assert property (@(posedge clk) disable iff (rst)
    writeSeen |=> rxEnable);

  p_dll_start_r8: assert property (@(posedge clk) disable iff (rst)
    (mrsSeen && legalWl && addrIn[DLL_BIT]) |=> dllResetPulse && dllResetBit);

  p_dll_pulse_flag_r9: assert property (@(posedge clk) disable iff (rst)
    dllResetPulse |-> dllResetBit);

endmodule

bind mrs_wl_sequencer mrs_wl_checker #(
  .ADDR_W(ADDR_W), .ALWAYS_ON_MAX(ALWAYS_ON_MAX)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cmdIn        (cmdIn),
  .addrIn       (addrIn),
  .writeLatency (writeLatency),
  .testMode     (testMode),
  .dllResetBit  (dllResetBit),
  .dllResetPulse(dllResetPulse),
  .rxEnable     (rxEnable),
  .capStrobe    (capStrobe)
);

// File: tb/sim_mrs_wl_sequencer.sv
`timescale 1ns/1ps
module sim_mrs_wl_sequencer;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 16;
  localparam int BL     = 1;
  localparam int AON    = 5;
  localparam int DLLC   = 16;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] cmdIn;
  logic [ADDR_W-1:0] addrIn;
  logic [DATA_W-1:0] dataIn;
  logic [2:0] writeLatency, wrRecovery;
  logic testMode, dllResetBit, dllResetPulse, rxEnable, capStrobe;
  logic [DATA_W-1:0] capData;

  always #2.5 clk = ~clk;

  mrs_wl_sequencer u0 (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .addrIn(addrIn), .dataIn(dataIn),
    .writeLatency(writeLatency), .wrRecovery(wrRecovery), .testMode(testMode),
    .dllResetBit(dllResetBit), .dllResetPulse(dllResetPulse),
    .rxEnable(rxEnable), .capStrobe(capStrobe), .capData(capData)
  );

  int checks = 0;
  int errors = 0;
  int edgeCnt = 0;
  int strobeCount = 0;
  bit expStrobe [4096];
  int mWL, mWR, mTM, mDll;
  bit restartFlag, expPulse;

  // vector: {addr, expected WL, expected WR, expected TM}
  localparam logic [19:0] VEC [6] = '{
    {13'h103D, 3'd3, 3'd5, 1'b0},
    {13'h0087, 3'd3, 3'd5, 1'b0},
    {13'h00F2, 3'd7, 3'd2, 1'b1},
    {13'h0E50, 3'd5, 3'd0, 1'b0},
    {13'h0001, 3'd5, 3'd0, 1'b0},
    {13'h0016, 3'd1, 3'd6, 1'b0}
  };

  function automatic logic [DATA_W-1:0] pat(int e);
    return DATA_W'(e * 37 + 11);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edgeCnt);
    end
  endtask

  task automatic tick();
    bit pendAhead;
    @(posedge clk);
    edgeCnt++;
    if (rst) begin
      mWL = 1; mWR = 0; mTM = 0; mDll = 0; expPulse = 0; restartFlag = 0;
      for (int j = edgeCnt; j < 4096; j++) expStrobe[j] = 0;
    end else begin
      if (restartFlag) begin mDll = DLLC; expPulse = 1; end
      else begin expPulse = 0; if (mDll > 0) mDll--; end
      restartFlag = 0;
    end
    @(negedge clk);
    if (capStrobe) strobeCount++;
    chk(writeLatency == 3'(mWL), "R2 latency", writeLatency, mWL);
    chk(wrRecovery == 3'(mWR), "R2 recovery", wrRecovery, mWR);
    chk(testMode == mTM[0], "R2 testmode", testMode, mTM);
    chk(dllResetBit == (mDll > 0), "R8 dll flag", dllResetBit, mDll > 0);
    chk(dllResetPulse == expPulse, "R8 dll pulse", dllResetPulse, expPulse);
    chk(capStrobe == expStrobe[edgeCnt], "R4 strobe", capStrobe, expStrobe[edgeCnt]);
    if (expStrobe[edgeCnt])
      chk(capData == pat(edgeCnt), "R4 data", capData, pat(edgeCnt));
    pendAhead = 0;
    for (int j = edgeCnt + 1; j <= edgeCnt + 8 + BL; j++) pendAhead |= expStrobe[j];
    if (mWL <= AON) chk(rxEnable == 1'b1, "R6 rx on", rxEnable, 1);
    else            chk(rxEnable == pendAhead, "R7 rx demand", rxEnable, pendAhead);
    dataIn = pat(edgeCnt + 1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic doMrs(input logic [ADDR_W-1:0] a);
    cmdIn = 2'b01; addrIn = a;
    if (a[6:4] != 3'd0) begin
      mWR = int'(a[2:0]); mWL = int'(a[6:4]); mTM = int'(a[7]);
      if (a[8] || mDll > 0) restartFlag = 1;
    end
    tick();
    cmdIn = 2'b00; addrIn = '0;
  endtask

  task automatic doWrite();
    cmdIn = 2'b10;
    for (int k = 0; k < BL; k++) expStrobe[edgeCnt + 1 + mWL + k] = 1;
    tick();
    cmdIn = 2'b00;
  endtask

  task automatic checkReset();
    chk(writeLatency == 3'd1, "R1 latency", writeLatency, 1);
    chk(wrRecovery == 3'd0, "R1 recovery", wrRecovery, 0);
    chk(!testMode && !dllResetBit, "R1 flags", {testMode, dllResetBit}, 0);
    chk(!capStrobe, "R1 strobe", capStrobe, 0);
    chk(rxEnable, "R1 rx", rxEnable, 1);
  endtask

  initial begin
    rst = 1; cmdIn = 2'b00; addrIn = '0; dataIn = '0;
    mWL = 1; mWR = 0; mTM = 0; mDll = 0; restartFlag = 0; expPulse = 0;
    idle(2);
    checkReset();
    rst = 0;
    idle(2);

    // table walk: decode and rejection
    foreach (VEC[i]) begin
      doMrs(VEC[i][19:7]);
      chk(writeLatency == VEC[i][6:4] && wrRecovery == VEC[i][3:1] && testMode == VEC[i][0],
          (VEC[i][13:11] != 3'd0) ? "R2 vector" : "R3 vector",
          {writeLatency, wrRecovery, testMode}, VEC[i][6:0]);
      idle(1);
    end

    // single writes at short latencies
    doWrite(); idle(3);
    doMrs(13'h0030); doWrite(); idle(5);

    // consecutive writes
    doMrs(13'h0020);
    strobeCount = 0;
    doWrite(); doWrite(); doWrite(); idle(6);
    chk(strobeCount == 3 * BL, "R5 count", strobeCount, 3 * BL);

    // on-demand receivers
    doMrs(13'h0060); idle(3);
    chk(rxEnable == 1'b0, "R7 idle low", rxEnable, 0);
    doWrite(); idle(10);
    doMrs(13'h0070); doWrite(); doWrite(); idle(2); doWrite(); idle(12);

    // latency change with a write in flight
    doWrite(); doMrs(13'h0020); doWrite(); idle(10);

    // DLL reset and restart
    doMrs(13'h0160); idle(5);
    doMrs(13'h0040); idle(10);
    chk(dllResetBit == 1'b1, "R9 restart holds", dllResetBit, 1);
    idle(6);
    chk(dllResetBit == 1'b0, "R8 self clear", dllResetBit, 0);
    doMrs(13'h0105);
    chk(dllResetPulse == 1'b0 && dllResetBit == 1'b0, "R3 no dll", {dllResetPulse, dllResetBit}, 0);
    idle(2);

    // reset with a write pending
    doMrs(13'h0070); doWrite(); idle(2);
    rst = 1; tick(); checkReset(); rst = 0;
    idle(12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule